// File: doc/BRIEF.md
# Reset Strap Capture and Boot Sequencer

This block sits beside a processor core and decides what the core does once a synchronous, active-high reset is released. While reset is held it keeps a clear request asserted toward the core's internal state. At the first clock edge where reset is seen low after being high, it samples two configuration straps. The first is an active-low flush strap, which selects the boot path. The second is a bus-frequency strap, which is held as the core-to-bus clock multiplier code for the clock generator outside this block.

With the flush strap high, the block starts a self-test and waits for its done handshake. It then spends a fixed number of cycles on initialisation and enters the run state. On entry to the run state it pulses a fetch strobe and presents the reset vector as the first fetch address. With the flush strap low, the block parks in a three-state test mode with all bus output enables off. Only a new reset releases it from that mode.

States and transitions: RESET goes to SELFTEST when the flush strap is high at release, or to TRISTATE_TEST when it is low. SELFTEST goes to INIT when the done input is high. INIT goes to RUN after INIT_CYCLES cycles. RUN and TRISTATE_TEST hold. Reset moves every state to RESET.

Top module: `boot_strap_seq`

## Requirements
- R1: `clear_req` is high in every cycle that follows a clock edge at which `rst` was high, and low in every other cycle.
- R2: Both straps are sampled only at the first edge where `rst` is low after an edge where it was high. From the next cycle, `ratio_code` shows the sampled `freq_strap`.
- R3: A flush strap of 1 at release moves the block to SELFTEST. `bist_start` is high for exactly the first cycle in SELFTEST.
- R4: Once captured, `ratio_code` does not change until the next reset, whatever the strap pins do.
- R5: SELFTEST lasts until an edge that sees `bist_done` high. INIT then lasts INIT_CYCLES cycles (default 4) before RUN. `bist_done` has no effect in any other state.
- R6: A flush strap of 0 at release moves the block to TRISTATE_TEST. There `tristate_mode` is 1 and `bus_oe` is 0, and only `rst` leaves the state. In every other state `bus_oe` is 1 and `tristate_mode` is 0.
- R7: `fetch_en` is high for exactly the first cycle in RUN. `fetch_addr` is 0xFFFF_FFF0 while in RUN and 0 otherwise.
- R8: An edge that sees `rst` high puts the block in RESET in the next cycle, from any state.
- R9: `state_o` encodes RESET=0, SELFTEST=1, INIT=2, RUN=3, TRISTATE_TEST=4.
- R10: `ratio_code` is 0 while the block is in RESET.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_strap_n | input | 1 | Active-low boot path strap |
| freq_strap | input | 3 | Bus-frequency strap |
| bist_done | input | 1 | Self-test completion handshake |
| ratio_code | output | 3 | Latched clock multiplier code |
| bist_start | output | 1 | One-cycle self-test start pulse |
| clear_req | output | 1 | Flush/clear request for internal state |
| tristate_mode | output | 1 | Three-state test mode flag |
| bus_oe | output | 1 | Output enable for all bus outputs |
| fetch_en | output | 1 | One-cycle first-fetch strobe |
| fetch_addr | output | 32 | Initial fetch address |
| state_o | output | 3 | Current sequencer state |

## Verification
Several properties are checked on every cycle. Reset always wins within one cycle and the clear request follows reset. The start and fetch strobes never last two cycles. The test mode is sticky, with output enables off. The captured ratio is held outside capture edges, and the initialisation timer never stays expired. Other behaviour can only be shown by the bench's scenarios, which compare each cycle against a model built from the requirements. These include which path the flush strap selects, the exact captured ratio value, the length of the wait on the done input, the INIT duration, and the fetch address value. They also show that straps toggled mid-sequence are ignored and that `bist_done` outside SELFTEST has no effect.

// File: rtl/boot_strap_pkg.sv
package boot_strap_pkg;

    typedef enum logic [2:0] {
        ST_RESET    = 3'd0,
        ST_SELFTEST = 3'd1,
        ST_INIT     = 3'd2,
        ST_RUN      = 3'd3,
        ST_TRITEST  = 3'd4
    } boot_state_e;

endpackage

// File: rtl/strap_latch.sv
module strap_latch #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture,
    input  logic [W-1:0] strap_in,
    output logic [W-1:0] strap_q
);

    always_ff @(posedge clk) begin
        if (rst)
            strap_q <= '0;
        else if (capture)
            strap_q <= strap_in;
    end

    AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(strap_q)); // R4

endmodule

// File: rtl/init_timer.sv
module init_timer #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (!expired)
            cnt <= cnt + CW'(1);
    end

    assign expired = run && (cnt == CW'(CYCLES - 1));

    AST_TIMER_ONCE: assert property (@(posedge clk) disable iff (rst)
        expired |=> !expired); // R5

endmodule

// File: rtl/boot_fsm.sv
module boot_fsm
    import boot_strap_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] RESET_VEC = 32'hFFFF_FFF0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush_n_strap,
    input  logic              bist_done,
    input  logic              timer_expired,
    output logic              capture,
    output boot_state_e       state_q,
    output logic              bist_start,
    output logic              clear_req,
    output logic              tristate_mode,
    output logic              bus_oe,
    output logic              fetch_en,
    output logic [ADDR_W-1:0] fetch_addr
);

    boot_state_e state_d;

    assign capture = (state_q == ST_RESET) && !rst;

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d = ST_RESET;
        end else begin
            unique case (state_q)
                ST_RESET:    state_d = flush_n_strap ? ST_SELFTEST : ST_TRITEST;
                ST_SELFTEST: if (bist_done) state_d = ST_INIT;
                ST_INIT:     if (timer_expired) state_d = ST_RUN;
                ST_RUN:      state_d = ST_RUN;
                ST_TRITEST:  state_d = ST_TRITEST;
                default:     state_d = ST_RESET;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        clear_req     <= (state_d == ST_RESET);
        bist_start    <= (state_d == ST_SELFTEST) && (state_q != ST_SELFTEST);
        fetch_en      <= (state_d == ST_RUN) && (state_q != ST_RUN);
        tristate_mode <= (state_d == ST_TRITEST);
        bus_oe        <= (state_d != ST_TRITEST);
        fetch_addr    <= (state_d == ST_RUN) ? RESET_VEC[ADDR_W-1:0] : '0;
    end

    AST_CLEAR_ON_RESET: assert property (@(posedge clk)
        rst |=> clear_req); // R1
    AST_RESET_WINS: assert property (@(posedge clk)
        rst |=> (state_q == ST_RESET)); // R8
    AST_BIST_PULSE: assert property (@(posedge clk) disable iff (rst)
        bist_start |=> !bist_start); // R3
    AST_FETCH_PULSE: assert property (@(posedge clk) disable iff (rst)
        fetch_en |=> !fetch_en); // R7
    AST_TEST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TRITEST) |=> (state_q == ST_TRITEST)); // R6
    AST_TEST_OE_OFF: assert property (@(posedge clk) disable iff (rst)
        tristate_mode |-> !bus_oe); // R6

endmodule

// File: rtl/boot_strap_seq.sv
module boot_strap_seq
    import boot_strap_pkg::*;
#(
    parameter int          FREQ_W      = 3,
    parameter int          INIT_CYCLES = 4,
    parameter int          ADDR_W      = 32,
    parameter logic [31:0] RESET_VEC   = 32'hFFFF_FFF0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush_strap_n,
    input  logic [FREQ_W-1:0] freq_strap,
    input  logic              bist_done,
    output logic [FREQ_W-1:0] ratio_code,
    output logic              bist_start,
    output logic              clear_req,
    output logic              tristate_mode,
    output logic              bus_oe,
    output logic              fetch_en,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [2:0]        state_o
);

    boot_state_e state;
    logic        capture;
    logic        init_done;

    strap_latch #(.W(FREQ_W)) u_ratio (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .strap_in (freq_strap),
        .strap_q  (ratio_code)
    );

    init_timer #(.CYCLES(INIT_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (state == ST_INIT),
        .expired (init_done)
    );

    boot_fsm #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .flush_n_strap (flush_strap_n),
        .bist_done     (bist_done),
        .timer_expired (init_done),
        .capture       (capture),
        .state_q       (state),
        .bist_start    (bist_start),
        .clear_req     (clear_req),
        .tristate_mode (tristate_mode),
        .bus_oe        (bus_oe),
        .fetch_en      (fetch_en),
        .fetch_addr    (fetch_addr)
    );

    assign state_o = state;

endmodule

// File: tb/boot_strap_seq_bench.sv
module boot_strap_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int INIT_N     = 4;
    localparam logic [31:0] VEC = 32'hFFFF_FFF0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush_strap_n = 1'b1;
    logic [2:0]  freq_strap = 3'd0;
    logic        bist_done = 1'b0;
    logic [2:0]  ratio_code;
    logic        bist_start, clear_req, tristate_mode, bus_oe, fetch_en;
    logic [31:0] fetch_addr;
    logic [2:0]  state_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int m_state = 0;
    int m_cnt = 0;
    int m_ratio = 0;
    int m_prev = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_strap_seq u_boot_strap_seq (
        .clk(clk), .rst(rst), .flush_strap_n(flush_strap_n),
        .freq_strap(freq_strap), .bist_done(bist_done),
        .ratio_code(ratio_code), .bist_start(bist_start),
        .clear_req(clear_req), .tristate_mode(tristate_mode),
        .bus_oe(bus_oe), .fetch_en(fetch_en), .fetch_addr(fetch_addr),
        .state_o(state_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int next_state(int cur, bit r, bit fn, bit done, int cnt);
        if (r) return 0;
        case (cur)
            0: return fn ? 1 : 4;
            1: return done ? 2 : 1;
            2: return (cnt == INIT_N - 1) ? 3 : 2;
            default: return cur;
        endcase
    endfunction

    task automatic step(input bit r, input bit fn, input logic [2:0] fr, input bit done);
        int nxt;
        rst = r; flush_strap_n = fn; freq_strap = fr; bist_done = done;
        @(posedge clk);
        nxt = next_state(m_state, r, fn, done, m_cnt);
        m_cnt = (nxt == 2 && m_state == 2) ? m_cnt + 1 : 0;
        if (r) m_ratio = 0;
        else if (m_state == 0) m_ratio = fr;
        m_prev = m_state;
        m_state = nxt;
        @(negedge clk);
        chk("R5 R8 R9 state", {29'd0, state_o}, m_state);
        chk("R1 clear_req", {31'd0, clear_req}, (m_state == 0) ? 1 : 0);
        chk("R3 bist_start", {31'd0, bist_start}, (m_state == 1 && m_prev != 1) ? 1 : 0);
        chk("R6 tristate_mode", {31'd0, tristate_mode}, (m_state == 4) ? 1 : 0);
        chk("R6 bus_oe", {31'd0, bus_oe}, (m_state == 4) ? 0 : 1);
        chk("R7 fetch_en", {31'd0, fetch_en}, (m_state == 3 && m_prev != 3) ? 1 : 0);
        chk("R7 fetch_addr", fetch_addr, (m_state == 3) ? VEC : 32'd0);
        chk("R2 R4 R10 ratio_code", {29'd0, ratio_code}, m_ratio);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // reset state
        step(1, 1, 3'd2, 0);
        step(1, 0, 3'd7, 1);
        // R2 R3: release with flush high, ratio 5
        step(0, 1, 3'd5, 0);
        // R4 R5: toggle straps and hold done low during self-test
        for (int i = 0; i < 6; i++) step(0, 1'($urandom), 3'($urandom), 0);
        step(0, 0, 3'd1, 1);
        // R5: INIT length, R7 fetch pulse; done ignored
        for (int i = 0; i < INIT_N + 4; i++) step(0, 1'($urandom), 3'($urandom), 1'($urandom));
        // R8: reset during self-test
        step(1, 1, 3'd0, 0);
        step(0, 1, 3'd3, 0);
        step(0, 1, 3'd3, 0);
        step(1, 1, 3'd3, 0);
        // R6: release with flush low, then stimulus must not leave test mode
        step(0, 0, 3'd6, 0);
        for (int i = 0; i < 8; i++) step(0, 1'($urandom), 3'($urandom), 1'($urandom));
        step(1, 1, 3'd0, 0);
        // R5: done already high at release
        step(0, 1, 3'd4, 1);
        for (int i = 0; i < INIT_N + 3; i++) step(0, 1, 3'd0, 1);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 20) == 0, ($urandom % 3) != 0, 3'($urandom),
                 ($urandom % 4) == 0);
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule